// File: doc/BRIEF.md
# Framed Serial Control Word Receiver

This block takes control words from a host over a three-wire framed serial link and presents them as a parallel command register. It divides the master clock by two to produce a free-running serial clock. The host can use that clock to shift data towards the block. While the frame input is high, one data bit is captured on every rising edge of the serial clock, most significant bit first. When a full word has arrived, the new value replaces the command register in a single step. If a frame ends before the word is complete, the partial word is thrown away.

One bit of the command word chooses which analog input pair feeds the downstream converter, and that bit is brought out as a separate select output. A chain output lets several receivers share one frame line. A mode pin sets its behaviour: with the pin high, the output drives a copy of the incoming frame, and with the pin low, its output enable is released so the line floats.

Top module: `ctl_serial_rx`

## Requirements
- R1: After reset, `sclk_o` changes level on every master clock edge, so it runs at exactly half the master clock frequency.
- R2: While `rst` is high, `sclk_o` is held high. After reset is released, `sclk_o` goes low on the first master clock edge and rises on the second.
- R3: `sdata_i` is sampled only at master clock edges where `sclk_o` rises and `frame_i` is high. Bits enter most significant bit first.
- R4: After the 16th sampled bit of a frame, `cmd_o` takes the whole received word at once. It does not change at any other edge. A frame held high across several word periods delivers one word per 16 bits.
- R5: If `frame_i` is low at a sampling edge before 16 bits have arrived, the partial word is discarded, `cmd_o` keeps its value, and the next frame starts counting from its first bit.
- R6: While `frame_i` is low, activity on `sdata_i` leaves `cmd_o` unchanged.
- R7: `aux_sel_o` equals bit 12 of `cmd_o`: 0 selects the primary analog inputs and 1 selects the auxiliary inputs.
- R8: When `chain_mode_i` is high, `frame_oe_o` is 1 and `frame_o` follows `frame_i` combinationally.
- R9: When `chain_mode_i` is low, `frame_oe_o` is 0, which places the chain output in high impedance, and `frame_o` is driven 0.
- R10: Reset clears `cmd_o` to zero, so the primary inputs are selected. This applies at power-up and in mid-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_o | output | 1 | Derived serial clock, master clock divided by two |
| frame_i | input | 1 | Active-high word frame |
| sdata_i | input | 1 | Serial control data, MSB first |
| chain_mode_i | input | 1 | High: repeat the frame on the chain output; low: release it |
| frame_o | output | 1 | Daisy-chain copy of the frame |
| frame_oe_o | output | 1 | Output enable for `frame_o` |
| cmd_o | output | 16 | Command register |
| aux_sel_o | output | 1 | Analog input select, 1 = auxiliary |

## Verification
The checker watches these rules on every cycle:
- the serial clock alternates level on each master clock edge;
- the command register is cleared after reset;
- the command register never changes on an edge where the serial clock is not rising, or where the frame is low;
- the select output tracks bit 12;
- the chain output and its enable follow the mode pin.

Some behaviour can only be shown by the bench scenarios:
- a word is assembled MSB first from the correct bits;
- a word loads only after exactly 16 bits;
- aborted frames are discarded and the bit count restarts;
- frames held high deliver back-to-back words;
- the divider phase right after reset is correct.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int WORD_W  = 16;
    localparam int SEL_BIT = 12;

    typedef enum logic {
        CHAIN_HIZ   = 1'b0,
        CHAIN_DRIVE = 1'b1
    } chain_mode_e;

    typedef struct packed {
        logic frame;
        logic oe;
    } chain_out_t;

endpackage

// File: rtl/ctl_clkdiv.sv
module ctl_clkdiv (
    input  logic clk,
    input  logic rst,
    output logic sclk_o,
    output logic sample_en_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= ~sclk_q;
    end

    assign sclk_o      = sclk_q;
    assign sample_en_o = ~sclk_q & ~rst;
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
    parameter int W = ctl_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_en,
    input  logic         frame_i,
    input  logic         sdata_i,
    output logic [W-1:0] cmd_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     cmd_q;
    logic [W-1:0]     next_sh;

    assign next_sh = {shreg_q[W-2:0], sdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
        end else if (sample_en) begin
            if (!frame_i) begin
                cnt_q <= '0;
            end else begin
                shreg_q <= next_sh;
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    cmd_q <= next_sh;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/ctl_chain.sv
module ctl_chain (
    input  logic                 frame_i,
    input  logic                 chain_mode_i,
    output ctl_pkg::chain_out_t  out_o
);
    ctl_pkg::chain_mode_e mode;

    always_comb begin
        mode = ctl_pkg::chain_mode_e'(chain_mode_i);
        if (mode == ctl_pkg::CHAIN_DRIVE) begin
            out_o.frame = frame_i;
            out_o.oe    = 1'b1;
        end else begin
            out_o.frame = 1'b0;
            out_o.oe    = 1'b0;
        end
    end
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx #(
    parameter int W   = ctl_pkg::WORD_W,
    parameter int SEL = ctl_pkg::SEL_BIT
) (
    input  logic         clk,
    input  logic         rst,
    output logic         sclk_o,
    input  logic         frame_i,
    input  logic         sdata_i,
    input  logic         chain_mode_i,
    output logic         frame_o,
    output logic         frame_oe_o,
    output logic [W-1:0] cmd_o,
    output logic         aux_sel_o
);
    logic                sample_en;
    ctl_pkg::chain_out_t chain;

    ctl_clkdiv u_div (
        .clk         (clk),
        .rst         (rst),
        .sclk_o      (sclk_o),
        .sample_en_o (sample_en)
    );

    ctl_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .frame_i   (frame_i),
        .sdata_i   (sdata_i),
        .cmd_o     (cmd_o)
    );

    ctl_chain u_chain (
        .frame_i      (frame_i),
        .chain_mode_i (chain_mode_i),
        .out_o        (chain)
    );

    assign frame_o    = chain.frame;
    assign frame_oe_o = chain.oe;
    assign aux_sel_o  = cmd_o[SEL];
endmodule

// File: rtl/ctl_serial_rx_chk.sv
module ctl_serial_rx_chk #(
    parameter int W   = 16,
    parameter int SEL = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         sclk_o,
    input logic         frame_i,
    input logic         chain_mode_i,
    input logic         frame_o,
    input logic         frame_oe_o,
    input logic [W-1:0] cmd_o,
    input logic         aux_sel_o
);
    // R1
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sclk_o != $past(sclk_o)));

    // R10
    cmd_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_o == '0));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |=> $stable(cmd_o));

    // R6
    cmd_noframe_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> $stable(cmd_o));

    // R7
    aux_sel_chk: assert property (@(posedge clk) disable iff (rst)
        aux_sel_o == cmd_o[SEL]);

    // R8
    chain_drive_chk: assert property (@(posedge clk) disable iff (rst)
        chain_mode_i |-> (frame_oe_o && frame_o == frame_i));

    // R9
    chain_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        !chain_mode_i |-> (!frame_oe_o && !frame_o));
endmodule

bind ctl_serial_rx ctl_serial_rx_chk #(.W(W), .SEL(SEL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sclk_o       (sclk_o),
    .frame_i      (frame_i),
    .chain_mode_i (chain_mode_i),
    .frame_o      (frame_o),
    .frame_oe_o   (frame_oe_o),
    .cmd_o        (cmd_o),
    .aux_sel_o    (aux_sel_o)
);

// File: tb/ctl_serial_rx_tb.sv
module ctl_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        chain_mode_i = 1'b0;
    logic        sclk_o, frame_o, frame_oe_o, aux_sel_o;
    logic [15:0] cmd_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ctl_serial_rx u_dut (
        .clk          (clk),
        .rst          (rst),
        .sclk_o       (sclk_o),
        .frame_i      (frame_i),
        .sdata_i      (sdata_i),
        .chain_mode_i (chain_mode_i),
        .frame_o      (frame_o),
        .frame_oe_o   (frame_oe_o),
        .cmd_o        (cmd_o),
        .aux_sel_o    (aux_sel_o)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [4:0]  nbits;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'hA5C3, 5'd16, 16'hA5C3},
        '{16'h1000, 5'd16, 16'h1000},
        '{16'hFFFF, 5'd8,  16'h1000},
        '{16'h0001, 5'd16, 16'h0001},
        '{16'h7FFE, 5'd15, 16'h0001},
        '{16'hEFFF, 5'd16, 16'hEFFF}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Wait for the falling clock edge before a sampling edge (sclk low), then drive.
    task automatic send_bit(input logic fr, input logic d);
        @(negedge clk);
        while (sclk_o !== 1'b0) @(negedge clk);
        frame_i = fr;
        sdata_i = d;
        @(posedge clk);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) send_bit(1'b1, w[i]);
    endtask

    task automatic idle_bit();
        send_bit(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: sclk held high in reset
        check(sclk_o === 1'b1, "R2", sclk_o, 1);
        // R10: command cleared, primary inputs
        check(cmd_o === 16'h0, "R10", cmd_o, 0);
        check(aux_sel_o === 1'b0, "R7", aux_sel_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sclk_o === 1'b0, "R2", sclk_o, 0);
        @(negedge clk);
        check(sclk_o === 1'b1, "R2", sclk_o, 1);
        for (int k = 0; k < 6; k++) begin
            logic prev;
            prev = sclk_o;
            @(negedge clk);
            // R1: toggles each master clock
            check(sclk_o !== prev, "R1", sclk_o, ~prev);
        end

        // Vector table: R3, R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            send_bits(VECS[v].word, int'(VECS[v].nbits));
            idle_bit();
            @(negedge clk);
            check(cmd_o === VECS[v].exp, "R3/R4/R5", cmd_o, VECS[v].exp);
            check(aux_sel_o === VECS[v].exp[12], "R7", aux_sel_o, VECS[v].exp[12]);
        end

        // R4: back-to-back words with frame held high
        send_bits(16'h1234, 16);
        @(negedge clk);
        check(cmd_o === 16'h1234, "R4", cmd_o, 16'h1234);
        send_bits(16'hBEEF, 15);
        @(negedge clk);
        check(cmd_o === 16'h1234, "R4", cmd_o, 16'h1234);
        send_bits(16'hFFFF, 1);
        @(negedge clk);
        check(cmd_o === 16'hBEEF, "R4", cmd_o, 16'hBEEF);
        idle_bit();

        // R6: data activity without frame
        for (int k = 0; k < 20; k++) send_bit(1'b0, k[0]);
        @(negedge clk);
        check(cmd_o === 16'hBEEF, "R6", cmd_o, 16'hBEEF);

        // R8 / R9: chain output
        @(negedge clk);
        chain_mode_i = 1'b1; frame_i = 1'b1;
        #1 check(frame_o === 1'b1 && frame_oe_o === 1'b1, "R8", {frame_o, frame_oe_o}, 2'b11);
        frame_i = 1'b0;
        #1 check(frame_o === 1'b0 && frame_oe_o === 1'b1, "R8", {frame_o, frame_oe_o}, 2'b01);
        chain_mode_i = 1'b0; frame_i = 1'b1;
        #1 check(frame_oe_o === 1'b0 && frame_o === 1'b0, "R9", {frame_o, frame_oe_o}, 2'b00);
        frame_i = 1'b0;

        // R10: mid-run reset
        send_bits(16'h1F00, 16);
        idle_bit();
        @(negedge clk);
        check(cmd_o === 16'h1F00 && aux_sel_o === 1'b1, "R7", {aux_sel_o, cmd_o}, {1'b1, 16'h1F00});
        rst = 1'b1;
        @(negedge clk);
        check(cmd_o === 16'h0 && aux_sel_o === 1'b0, "R10", cmd_o, 0);
        rst = 1'b0;
        send_bits(16'h0ABC, 16);
        @(negedge clk);
        check(cmd_o === 16'h0ABC, "R4", cmd_o, 16'h0ABC);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule